// File: doc/BRIEF.md
# Integer Execute Unit

This block is the combinational execute stage of a 32-bit processor datapath. Each cycle it receives a 6-bit opcode, two register operands and a 16-bit immediate field. It returns a 32-bit result and a flag that tells the pipeline whether the opcode belongs to this unit. The unit covers addition, subtraction, low-word multiplication, four bitwise functions, three shift kinds and an upper-immediate load. Every operation except the upper-immediate load comes in a register-register form and a register-immediate form.

The immediate field is widened according to the opcode. Arithmetic-immediate forms treat it as signed. The unsigned multiply and the bitwise-immediate forms treat it as unsigned. Division and remainder opcodes are routed to another unit. This block flags them as not handled.

The block has no clock and no state. It has no data stream, so no valid/ready handshake applies. The result can be captured by whatever pipeline register follows the block.

Top module: `int_exec_unit`

## Requirements
- R1: `valid_o` is 1 for opcodes 0x00 to 0x07, 0x10 to 0x1D and 0x1F. It is 0 for 0x08 to 0x0F, for 0x1E and for every opcode from 0x20 upward.
- R2: When opcode bit 0 is 1, the widened immediate replaces `src_b_i` as the second operand, and `src_b_i` has no effect. When bit 0 is 0, `src_b_i` is used and `imm_i` has no effect, except for opcode 0x1F.
- R3: Opcodes 0x00/0x01 return the low 32 bits of a+b. Opcodes 0x02/0x03 return the low 32 bits of a-b.
- R4: Opcodes 0x04/0x05 (signed) and 0x06/0x07 (unsigned) return the low 32 bits of a*b.
- R5: Opcodes 0x01, 0x03 and 0x05 sign-extend `imm_i` to 32 bits (bit 15 copied upward). Opcodes 0x07, 0x11, 0x13, 0x15 and 0x17 zero-extend it.
- R6: Opcodes 0x10/0x11 return a AND b. Opcodes 0x12/0x13 return a OR b. Opcodes 0x14/0x15 return a XOR b. Opcodes 0x16/0x17 return NOT(a XOR b).
- R7: A shift uses only bits 4..0 of its second operand as the shift distance. The higher bits have no effect, so a distance of 32 behaves as 0.
- R8: Opcodes 0x18/0x19 shift left and fill with zeros. Opcodes 0x1A/0x1B shift right and fill with zeros. Opcodes 0x1C/0x1D shift right and fill with bit 31 of `src_a_i`.
- R9: Opcode 0x1F returns `imm_i` in bits 31..16 and zeros in bits 15..0, regardless of both register operands.
- R10: Whenever `valid_o` is 0, `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Operation code |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field of the instruction |
| result_o | output | 32 | Computed result, zero when not handled |
| valid_o | output | 1 | Opcode is handled by this unit |

## Verification
The bench sweeps all 64 opcodes over operand sets that include 0, 0x80000000, 0xFFFFFFFF and immediates with bit 15 set and clear.

- Immediates with bit 15 set expose a wrong widening rule. A design that picks the rule per operation class instead of per opcode gives wrong upper bits for MULUI or ADDI.
- Shift distances of 0, 31 and 32 separate a correct 5-bit mask from a full-width shift. A full-width shift would return zero for a distance of 32.
- Operand 0x80000000 separates arithmetic fill from logical fill.
- The 0x1E hole and the division range catch a decoder that is too generous. Such a decoder would raise `valid_o` or leak a nonzero result.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int OPC_W = 6;
  localparam int GRP_W = 3;

  localparam logic [GRP_W-1:0] GRP_ARITH  = 3'b000;
  localparam logic [GRP_W-1:0] GRP_LOGIC  = 3'b010;
  localparam logic [GRP_W-1:0] GRP_SHIFT  = 3'b011;

  typedef enum logic [1:0] {
    ARI_ADD  = 2'b00,
    ARI_SUB  = 2'b01,
    ARI_MULS = 2'b10,
    ARI_MULU = 2'b11
  } ari_fn_e;

  typedef enum logic [1:0] {
    LGC_AND  = 2'b00,
    LGC_OR   = 2'b01,
    LGC_XOR  = 2'b10,
    LGC_XNOR = 2'b11
  } lgc_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'b00,
    SH_RIGHTL = 2'b01,
    SH_RIGHTA = 2'b10,
    SH_UPIMM  = 2'b11
  } sh_fn_e;
endpackage

// File: rtl/iexu_imm_ext.sv
module iexu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sign_en_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill;
  assign fill  = sign_en_i & imm_i[IMM_W-1];
  assign ext_o = {{PAD_W{fill}}, imm_i};

  // Low part passes through; upper part is uniform
  always_comb begin
    AST_EXT_SHAPE: assert (ext_o[IMM_W-1:0] == imm_i &&
      ((&ext_o[DATA_W-1:IMM_W-1]) || !(|ext_o[DATA_W-1:IMM_W]))); // R5
  end
endmodule

// File: rtl/iexu_arith.sv
module iexu_arith
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  ari_fn_e           fn_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] sum, diff, prod;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  // Low word of a product is identical for signed and unsigned operands
  assign prod = a_i * b_i;

  always_comb begin
    unique case (fn_i)
      ARI_ADD:  y_o = sum;
      ARI_SUB:  y_o = diff;
      default:  y_o = prod;
    endcase
  end

  always_comb begin
    if (fn_i == ARI_SUB) begin
      AST_SUB_INVERSE: assert (DATA_W'(y_o + b_i) == a_i); // R3
    end
  end
endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lgc_fn_e           fn_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] x;
  assign x = a_i ^ b_i;

  always_comb begin
    unique case (fn_i)
      LGC_AND:  y_o = a_i & b_i;
      LGC_OR:   y_o = a_i | b_i;
      LGC_XOR:  y_o = x;
      default:  y_o = ~x;
    endcase
  end

  always_comb begin
    if (fn_i == LGC_AND) begin
      AST_AND_SUBSET: assert ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0); // R6
    end
  end
endmodule

// File: rtl/iexu_shifter.sv
module iexu_shifter
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  sh_fn_e            fn_i,
  output logic [DATA_W-1:0] y_o
);
  logic              left, fill;
  logic [DATA_W-1:0] pre, post;
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign left = (fn_i == SH_LEFT);
  assign fill = (fn_i == SH_RIGHTA) & val_i[DATA_W-1];

  // Left shifts reuse the right shifter by mirroring around it
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign pre[i]  = left ? val_i[DATA_W-1-i] : val_i[i];
    assign y_o[i]  = left ? post[DATA_W-1-i] : post[i];
  end

  assign stage[0] = pre;
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k]
      ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]}
      : stage[k];
  end
  assign post = stage[AMT_W];

  always_comb begin
    if (amt_i == '0) begin
      AST_ZERO_DIST_IDENT: assert (y_o == val_i); // R7
    end
    if (left) begin
      AST_LEFT_LOW_CLEAR: assert ((y_o & ((DATA_W'(1) << amt_i) - DATA_W'(1))) == '0); // R8
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  logic [GRP_W-1:0]  grp;
  logic [1:0]        fn;
  logic              use_imm, sign_en;
  logic [DATA_W-1:0] imm_ext, opnd_b;
  logic [DATA_W-1:0] ari_y, lgc_y, sh_y, upimm_y;
  logic [DATA_W-1:0] sel_y;

  assign grp     = opcode_i[OPC_W-1:OPC_W-GRP_W];
  assign fn      = opcode_i[2:1];
  assign use_imm = opcode_i[0];
  // Arithmetic immediates are signed except for the unsigned multiply
  assign sign_en = (grp == GRP_ARITH) && (fn != ARI_MULU);

  iexu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm_i     (imm_i),
    .sign_en_i (sign_en),
    .ext_o     (imm_ext)
  );

  assign opnd_b = use_imm ? imm_ext : src_b_i;

  iexu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i  (src_a_i),
    .b_i  (opnd_b),
    .fn_i (ari_fn_e'(fn)),
    .y_o  (ari_y)
  );

  iexu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (src_a_i),
    .b_i  (opnd_b),
    .fn_i (lgc_fn_e'(fn)),
    .y_o  (lgc_y)
  );

  iexu_shifter #(.DATA_W(DATA_W)) u_shift (
    .val_i (src_a_i),
    .amt_i (opnd_b[AMT_W-1:0]),
    .fn_i  (sh_fn_e'(fn)),
    .y_o   (sh_y)
  );

  assign upimm_y = {imm_i, {(DATA_W-IMM_W){1'b0}}};

  always_comb begin
    valid_o = 1'b0;
    sel_y   = '0;
    unique case (grp)
      GRP_ARITH: begin
        valid_o = 1'b1;
        sel_y   = ari_y;
      end
      GRP_LOGIC: begin
        valid_o = 1'b1;
        sel_y   = lgc_y;
      end
      GRP_SHIFT: begin
        if (fn == SH_UPIMM) begin
          valid_o = use_imm;
          sel_y   = upimm_y;
        end else begin
          valid_o = 1'b1;
          sel_y   = sh_y;
        end
      end
      default: begin
        valid_o = 1'b0;
        sel_y   = '0;
      end
    endcase
  end

  assign result_o = valid_o ? sel_y : '0;

  always_comb begin
    if (valid_o && grp == GRP_SHIFT && fn == SH_UPIMM) begin
      AST_UPIMM_LOW_ZERO: assert (result_o[IMM_W-1:0] == '0); // R9
    end
    if (opcode_i[OPC_W-1]) begin
      AST_HIGH_OPC_REJECT: assert (!valid_o && result_o == '0); // R1
    end
  end
endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opc;
  logic [31:0] a, b;
  logic [15:0] im;
  logic [31:0] res;
  logic        vld;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .opcode_i (opc),
    .src_a_i  (a),
    .src_b_i  (b),
    .imm_i    (im),
    .result_o (res),
    .valid_o  (vld)
  );

  localparam logic [31:0] AV [7] = '{32'h0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF,
                                    32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF};
  localparam logic [31:0] BV [7] = '{32'h0, 32'h1, 32'h1F, 32'h20,
                                    32'h8000_0000, 32'hFFFF_FFFF, 32'hABCD_0023};
  localparam logic [15:0] IV [7] = '{16'h0, 16'h1, 16'h001F, 16'h8000,
                                    16'hFFFF, 16'h7FFF, 16'h1234};

  function automatic logic [31:0] model(input logic [5:0] op, input logic [31:0] x,
                                        input logic [31:0] y, input logic [15:0] i,
                                        output logic ok);
    logic [31:0] sx, zx;
    logic signed [63:0] p;
    logic [31:0] r;
    sx = {{16{i[15]}}, i};
    zx = {16'h0000, i};
    ok = 1'b1;
    case (op)
      6'h00: r = x + y;
      6'h01: r = x + sx;
      6'h02: r = x - y;
      6'h03: r = x - sx;
      6'h04: begin p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y}); r = p[31:0]; end
      6'h05: begin p = $signed({{32{x[31]}}, x}) * $signed({{32{sx[31]}}, sx}); r = p[31:0]; end
      6'h06: r = x * y;
      6'h07: r = x * zx;
      6'h10: r = x & y;
      6'h11: r = x & zx;
      6'h12: r = x | y;
      6'h13: r = x | zx;
      6'h14: r = x ^ y;
      6'h15: r = x ^ zx;
      6'h16: r = ~(x ^ y);
      6'h17: r = ~(x ^ zx);
      6'h18: r = x << y[4:0];
      6'h19: r = x << i[4:0];
      6'h1A: r = x >> y[4:0];
      6'h1B: r = x >> i[4:0];
      6'h1C: r = 32'($signed(x) >>> y[4:0]);
      6'h1D: r = 32'($signed(x) >>> i[4:0]);
      6'h1F: r = {i, 16'h0000};
      default: begin r = 32'h0; ok = 1'b0; end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    if (op == 6'h01 || op == 6'h03 || op == 6'h05 || op == 6'h07 ||
        op == 6'h11 || op == 6'h13 || op == 6'h15 || op == 6'h17) return "R5";
    if (op <= 6'h03) return "R3";
    if (op <= 6'h07) return "R4";
    if (op >= 6'h10 && op <= 6'h17) return "R6";
    if (op >= 6'h18 && op <= 6'h1D) return "R8";
    if (op == 6'h1F) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s opc=%02h a=%08h b=%08h imm=%04h actual=%08h expected=%08h",
               req, opc, a, b, im, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] i);
    @(negedge clk);
    opc = o; a = x; b = y; im = i;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic ok;
    logic [31:0] e;
    opc = 6'h00; a = '0; b = '0; im = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Idle state: ADD of zeros
    check("R1", {31'b0, vld}, 32'h1);
    check("R3", res, 32'h0);

    // Full opcode sweep
    for (int o = 0; o < 64; o++)
      for (int ia = 0; ia < 7; ia++)
        for (int ib = 0; ib < 7; ib++)
          for (int ii = 0; ii < 7; ii++) begin
            apply(6'(o), AV[ia], BV[ib], IV[ii]);
            e = model(6'(o), AV[ia], BV[ib], IV[ii], ok);
            check("R1", {31'b0, vld}, {31'b0, ok});
            check(tag_of(6'(o)), res, e);
          end

    // R2: immediate form ignores src_b
    apply(6'h01, 32'h10, 32'hFFFF_0000, 16'h0005);
    check("R2", res, 32'h15);
    apply(6'h00, 32'h10, 32'h3, 16'hFFFF);
    check("R2", res, 32'h13);
    // R5: same field, signed vs unsigned widening
    apply(6'h03, 32'h0, 32'h0, 16'hFFFF);
    check("R5", res, 32'h1);
    apply(6'h13, 32'h0, 32'h0, 16'hFFFF);
    check("R5", res, 32'h0000_FFFF);
    // R7: distance 32 acts as 0, distance 31 moves bit 0 to top
    apply(6'h18, 32'hA5A5_A5A5, 32'h0000_0020, 16'h0);
    check("R7", res, 32'hA5A5_A5A5);
    apply(6'h19, 32'h1, 32'h0, 16'hFFDF);
    check("R7", res, 32'h8000_0000);
    // R8: arithmetic fill of the sign bit
    apply(6'h1C, 32'h8000_0000, 32'h1F, 16'h0);
    check("R8", res, 32'hFFFF_FFFF);
    // R9: register operands ignored
    apply(6'h1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF);
    check("R9", res, 32'hBEEF_0000);
    // R10 / R1: hole at 0x1E and division range
    apply(6'h1E, 32'hFFFF_FFFF, 32'h3, 16'hFFFF);
    check("R10", res, 32'h0);
    check("R1", {31'b0, vld}, 32'h0);
    apply(6'h08, 32'h64, 32'h5, 16'h5);
    check("R10", res, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule